// File: doc/BRIEF.md
# RAM Read Path with Staged Output Reset

A single-port synchronous RAM whose read data passes through two storage stages before leaving the block. The first stage, called the latch stage here, captures the addressed word on any clock edge where the port enable is high. An optional second stage, the output register, copies the latch stage on edges where the register enable is high. Both stages can be driven to a parameterised reset value by the reset input `rst_ni`. Parameters decide three things: whether reset acts at a clock edge or at once, whether reset outranks the stage enable or depends on it, and whether the output register sits in general logic instead of inside the memory.

The block answers one question: for how many cycles the reset value is visible on `rdata_o`, and in which cycle it is released. That depends on the order in which the two enables are raised, and not only on when reset is asserted. A designer picks the variant that matches the pipeline control around the memory. Writes go into the array on any edge where both the port enable and the write enable are high. A read in the same cycle returns the old contents.

Top module: `ram_rdpath`

## Requirements
- R1: With reset priority (`RST_PRIO` = PRIO_RST), at a clock edge where `rst_ni` is 0, each stage that has a reset loads `RST_VAL` whatever its enable, so `rdata_o` equals `RST_VAL` in the following cycle.
- R2: With enable priority (`RST_PRIO` = PRIO_EN, synchronous), a stage clears only at an edge where `rst_ni` is 0 and its own enable is 1. With its enable at 0 the stage keeps its value while reset is held.
- R3: With enable priority, a reset seen at an edge with `en_i`=1 and `reg_en_i`=0 clears only the latch stage. `rdata_o` keeps its previous value until the first edge with `reg_en_i`=1, and from that edge on it shows `RST_VAL`.
- R4: With both enables at 1 and reset low for one edge, `rdata_o` shows `RST_VAL` for two cycles, then the addressed data.
- R5: With reset priority and the output register present, once reset is released `rdata_o` keeps `RST_VAL` until the latch stage has been enabled at one edge and the output register at a later edge.
- R6: With `FABRIC_REG`=1 the latch stage has no reset. The output register clears at any edge with reset low, whatever its enable. After release it holds `RST_VAL` until the first edge with `reg_en_i`=1, when it takes the latch contents.
- R7: With `ASYNC_RST`=1, `rdata_o` becomes `RST_VAL` as soon as `rst_ni` falls, with no clock edge, whatever the enables. Release follows the rules of R5.
- R8: Read latency from an edge with `en_i`=1 is one cycle without the output register. With the register and `reg_en_i`=1 on the next edge, it is two cycles.
- R9: A write happens only at an edge with `en_i`=1 and `we_i`=1. A read of the address being written returns the old word. With `en_i`=0 the array and the latch stage are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Output stage reset, active low (synchronous or asynchronous per `ASYNC_RST`) |
| en_i | input | 1 | Port enable: gates writes and the latch stage |
| reg_en_i | input | 1 | Output register enable |
| we_i | input | 1 | Write enable |
| addr_i | input | $clog2(DEPTH) | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data after the configured stages |

## Verification
Five instances run side by side on one stimulus stream, one for each reset variant: enable priority, reset priority, asynchronous, general-logic register and no output register. The bench targets reset held with only one of the two enables high. A design that ignored enable priority would clear the output at once in that case. A design that reset both stages would show `RST_VAL` before `reg_en_i` rises. The bench also checks release when the enables come back in the wrong order: a reset-priority design that released on the register enable alone would expose stale data early. Further targets are the two-cycle reset window, an asynchronous clear between clock edges, a general-logic register that wrongly resets the latch (it would release to `RST_VAL` instead of memory data), and a read of the address being written.

// File: rtl/ram_rdpath_pkg.sv
package ram_rdpath_pkg;
  typedef enum logic {
    PRIO_EN  = 1'b0,
    PRIO_RST = 1'b1
  } rst_prio_e;
endpackage

// File: rtl/ram_rdpath_mem.sv
module ram_rdpath_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // old word is visible during the write edge: read-first
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/ram_rdpath_stage.sv
module ram_rdpath_stage #(
  parameter int                        DATA_W   = 8,
  parameter logic [DATA_W-1:0]         RST_VAL  = '0,
  parameter bit                        HAS_RST  = 1'b1,
  parameter bit                        ASYNC    = 1'b0,
  parameter ram_rdpath_pkg::rst_prio_e PRIO     = ram_rdpath_pkg::PRIO_EN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  if (!HAS_RST) begin : g_norst
    logic unused_rst;
    assign unused_rst = rst_ni;
    always_ff @(posedge clk_i) begin
      if (en_i) q_q <= d_i;
    end
  end else if (ASYNC) begin : g_async
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_q <= RST_VAL;
      else if (en_i) q_q <= d_i;
    end
  end else if (PRIO == ram_rdpath_pkg::PRIO_RST) begin : g_rst_prio
    always_ff @(posedge clk_i) begin
      if (!rst_ni)   q_q <= RST_VAL;
      else if (en_i) q_q <= d_i;
    end
  end else begin : g_en_prio
    // reset only acts through the enable
    always_ff @(posedge clk_i) begin
      if (en_i) q_q <= rst_ni ? d_i : RST_VAL;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/ram_rdpath.sv
module ram_rdpath #(
  parameter int                        DATA_W     = 8,
  parameter int                        DEPTH      = 16,
  parameter logic [DATA_W-1:0]         RST_VAL    = '0,
  parameter bit                        OUT_REG    = 1'b1,
  parameter bit                        FABRIC_REG = 1'b0,
  parameter bit                        ASYNC_RST  = 1'b0,
  parameter ram_rdpath_pkg::rst_prio_e RST_PRIO   = ram_rdpath_pkg::PRIO_EN,
  localparam int                       AW         = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              reg_en_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  import ram_rdpath_pkg::*;

  localparam bit        LatchHasRst = !(OUT_REG && FABRIC_REG);
  localparam rst_prio_e RegPrio     = (FABRIC_REG || RST_PRIO == PRIO_RST) ? PRIO_RST : PRIO_EN;

  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] latch_q;

  ram_rdpath_mem #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (en_i & we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (arr_rd)
  );

  ram_rdpath_stage #(
    .DATA_W  (DATA_W),
    .RST_VAL (RST_VAL),
    .HAS_RST (LatchHasRst),
    .ASYNC   (ASYNC_RST),
    .PRIO    (RST_PRIO)
  ) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (arr_rd),
    .q_o    (latch_q)
  );

  if (OUT_REG) begin : g_oreg
    logic [DATA_W-1:0] oreg_q;
    ram_rdpath_stage #(
      .DATA_W  (DATA_W),
      .RST_VAL (RST_VAL),
      .HAS_RST (1'b1),
      .ASYNC   (ASYNC_RST),
      .PRIO    (RegPrio)
    ) u_oreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (reg_en_i),
      .d_i    (latch_q),
      .q_o    (oreg_q)
    );
    assign rdata_o = oreg_q;
  end else begin : g_noreg
    logic unused_reg_en;
    assign unused_reg_en = reg_en_i;
    assign rdata_o = latch_q;
  end
endmodule

// File: rtl/ram_rdpath_chk.sv
module ram_rdpath_chk #(
  parameter int                        DATA_W     = 8,
  parameter logic [DATA_W-1:0]         RST_VAL    = '0,
  parameter bit                        OUT_REG    = 1'b1,
  parameter bit                        FABRIC_REG = 1'b0,
  parameter bit                        ASYNC_RST  = 1'b0,
  parameter ram_rdpath_pkg::rst_prio_e RST_PRIO   = ram_rdpath_pkg::PRIO_EN
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              reg_en_i,
  input logic [DATA_W-1:0] rdata_o
);
  import ram_rdpath_pkg::*;

  localparam bit EnPrioSync = !ASYNC_RST && RST_PRIO == PRIO_EN;
  localparam bit RegRstPrio = ASYNC_RST || FABRIC_REG || RST_PRIO == PRIO_RST;

  bit armed_q;
  always_ff @(posedge clk_i) armed_q <= 1'b1;

  p_rst_clear_r1: assert property (@(posedge clk_i) disable iff (!armed_q)
    (OUT_REG && RegRstPrio && !rst_ni) |=> rdata_o == RST_VAL);

  p_en_hold_r2: assert property (@(posedge clk_i) disable iff (!armed_q)
    (OUT_REG && EnPrioSync && !FABRIC_REG && !reg_en_i) |=> $stable(rdata_o));

  p_latch_to_reg_r3: assert property (@(posedge clk_i) disable iff (!armed_q)
    (OUT_REG && !FABRIC_REG && reg_en_i && $past(!rst_ni && en_i)) |=> rdata_o == RST_VAL);

  p_fab_hold_r6: assert property (@(posedge clk_i) disable iff (!armed_q)
    (OUT_REG && FABRIC_REG && !ASYNC_RST && rst_ni && !reg_en_i) |=> $stable(rdata_o));

  p_async_clear_r7: assert property (@(posedge clk_i) disable iff (!armed_q)
    (ASYNC_RST && !rst_ni) |-> rdata_o == RST_VAL);

  p_noreg_hold_r9: assert property (@(posedge clk_i) disable iff (!armed_q)
    (!OUT_REG && EnPrioSync && !en_i) |=> $stable(rdata_o));
endmodule

bind ram_rdpath ram_rdpath_chk #(
  .DATA_W     (DATA_W),
  .RST_VAL    (RST_VAL),
  .OUT_REG    (OUT_REG),
  .FABRIC_REG (FABRIC_REG),
  .ASYNC_RST  (ASYNC_RST),
  .RST_PRIO   (RST_PRIO)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .reg_en_i (reg_en_i),
  .rdata_o  (rdata_o)
);

// File: tb/ram_rdpath_tb.sv
module ram_rdpath_tb;
  localparam int             W     = 8;
  localparam int             DEPTH = 16;
  localparam int             AW    = $clog2(DEPTH);
  localparam logic [W-1:0]   RV    = 8'hA5;
  localparam int             NCFG  = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, reg_en_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [W-1:0]  wdata_i = '0;
  logic [NCFG-1:0][W-1:0] q_all;

  always #5 clk_i = ~clk_i;

  // 0: enable prio, 1: reset prio, 2: async, 3: general-logic register, 4: no register
  ram_rdpath #(.DATA_W(W), .DEPTH(DEPTH), .RST_VAL(RV), .OUT_REG(1'b1),
    .RST_PRIO(ram_rdpath_pkg::PRIO_EN)) u_dut (
    .clk_i, .rst_ni, .en_i, .reg_en_i, .we_i, .addr_i, .wdata_i, .rdata_o(q_all[0]));
  ram_rdpath #(.DATA_W(W), .DEPTH(DEPTH), .RST_VAL(RV), .OUT_REG(1'b1),
    .RST_PRIO(ram_rdpath_pkg::PRIO_RST)) u_dut_rp (
    .clk_i, .rst_ni, .en_i, .reg_en_i, .we_i, .addr_i, .wdata_i, .rdata_o(q_all[1]));
  ram_rdpath #(.DATA_W(W), .DEPTH(DEPTH), .RST_VAL(RV), .OUT_REG(1'b1), .ASYNC_RST(1'b1),
    .RST_PRIO(ram_rdpath_pkg::PRIO_EN)) u_dut_as (
    .clk_i, .rst_ni, .en_i, .reg_en_i, .we_i, .addr_i, .wdata_i, .rdata_o(q_all[2]));
  ram_rdpath #(.DATA_W(W), .DEPTH(DEPTH), .RST_VAL(RV), .OUT_REG(1'b1), .FABRIC_REG(1'b1),
    .RST_PRIO(ram_rdpath_pkg::PRIO_EN)) u_dut_fb (
    .clk_i, .rst_ni, .en_i, .reg_en_i, .we_i, .addr_i, .wdata_i, .rdata_o(q_all[3]));
  ram_rdpath #(.DATA_W(W), .DEPTH(DEPTH), .RST_VAL(RV), .OUT_REG(1'b0),
    .RST_PRIO(ram_rdpath_pkg::PRIO_EN)) u_dut_nr (
    .clk_i, .rst_ni, .en_i, .reg_en_i, .we_i, .addr_i, .wdata_i, .rdata_o(q_all[4]));

  typedef struct {
    logic [NCFG-1:0][W-1:0] exp;
    string                  req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_mem [DEPTH];
  logic [W-1:0] m_l [NCFG];
  logic [W-1:0] m_r [NCFG];

  function automatic bit cfg_rprio(int c); return c == 1 || c == 2; endfunction
  function automatic bit cfg_fab(int c);   return c == 3;           endfunction
  function automatic bit cfg_oreg(int c);  return c != 4;           endfunction

  // reference model: one clock edge with the inputs currently applied
  task automatic model_edge();
    logic [W-1:0] rd;
    logic rst;
    rd  = m_mem[addr_i];
    rst = !rst_ni;
    for (int c = 0; c < NCFG; c++) begin
      logic [W-1:0] nl, nr;
      if (!cfg_fab(c) && rst && (cfg_rprio(c) || en_i)) nl = RV;
      else if (en_i)                                    nl = rd;
      else                                              nl = m_l[c];
      if (rst && (cfg_rprio(c) || cfg_fab(c) || reg_en_i)) nr = RV;
      else if (reg_en_i)                                    nr = m_l[c];
      else                                                  nr = m_r[c];
      m_l[c] = nl;
      m_r[c] = nr;
    end
    if (en_i && we_i) m_mem[addr_i] = wdata_i;
  endtask

  task automatic step(input bit en, input bit ren, input bit we, input int a,
                      input int d, input bit rst, input string req, input bit chk);
    item_t it;
    @(posedge clk_i);
    #1;
    model_edge();
    en_i     = en;
    reg_en_i = ren;
    we_i     = we;
    addr_i   = AW'(a);
    wdata_i  = W'(d);
    rst_ni   = !rst;
    if (rst) begin
      m_l[2] = RV;
      m_r[2] = RV;
    end
    if (chk) begin
      for (int c = 0; c < NCFG; c++) it.exp[c] = cfg_oreg(c) ? m_r[c] : m_l[c];
      it.req = req;
      sb.push_back(it);
    end
  endtask

  // monitor: compare every configuration away from the rising edge
  always @(negedge clk_i) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      for (int c = 0; c < NCFG; c++) begin
        checks++;
        if (q_all[c] !== it.exp[c]) begin
          errors++;
          $display("FAIL %s cfg%0d: actual=%02h expected=%02h at %0t",
                   it.req, c, q_all[c], it.exp[c], $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lfsr;
    // bring-up: reset with both enables, fill the array, flush both stages
    step(1, 1, 0, 0, 0, 1, "init", 0);
    step(1, 1, 0, 0, 0, 1, "init", 0);
    for (int a = 0; a < DEPTH; a++) step(1, 1, 1, a, a * 7 + 1, 0, "init", 0);
    step(1, 1, 0, 0, 0, 0, "init", 0);
    step(1, 1, 0, 0, 0, 0, "init", 0);
    step(1, 1, 0, 0, 0, 0, "init", 0);

    // R8: latency with back-to-back reads
    step(1, 1, 0, 3, 0, 0, "R8", 1);
    step(1, 1, 0, 4, 0, 0, "R8", 1);
    step(1, 1, 0, 5, 0, 0, "R8", 1);
    step(0, 1, 0, 5, 0, 0, "R8", 1);
    step(0, 0, 0, 5, 0, 0, "R8", 1);

    // R9: read-first write, then write with en_i low is dropped
    step(1, 1, 1, 6, 8'h3C, 0, "R9", 1);
    step(1, 1, 0, 6, 0, 0, "R9", 1);
    step(0, 1, 1, 7, 8'hFF, 0, "R9", 1);
    step(0, 1, 0, 7, 0, 0, "R9", 1);
    step(1, 1, 0, 7, 0, 0, "R9", 1);
    step(1, 1, 0, 6, 0, 0, "R9", 1);
    step(0, 1, 0, 6, 0, 0, "R9", 1);

    // R4: one-edge reset with both enables
    step(1, 1, 0, 2, 0, 1, "R4", 1);
    step(1, 1, 0, 2, 0, 0, "R4", 1);
    step(1, 1, 0, 2, 0, 0, "R4", 1);
    step(1, 1, 0, 2, 0, 0, "R4", 1);
    step(1, 1, 0, 2, 0, 0, "R4", 1);

    // R3: reset with latch enabled only, register enable raised later
    step(1, 1, 0, 1, 0, 0, "R3", 1);
    step(1, 0, 0, 1, 0, 1, "R3", 1);
    step(0, 0, 0, 1, 0, 0, "R3", 1);
    step(0, 0, 0, 1, 0, 0, "R3", 1);
    step(0, 1, 0, 1, 0, 0, "R3", 1);
    step(0, 1, 0, 1, 0, 0, "R3", 1);

    // R2: reset with both enables low, held, then released
    step(1, 1, 0, 9, 0, 0, "R2", 1);
    step(0, 1, 0, 9, 0, 0, "R2", 1);
    step(0, 0, 0, 9, 0, 1, "R2", 1);
    step(0, 0, 0, 9, 0, 1, "R2", 1);
    step(0, 0, 0, 9, 0, 0, "R2", 1);
    step(0, 0, 0, 9, 0, 0, "R2", 1);

    // R5 / R6: release order: register first, then latch, then register
    step(0, 1, 0, 10, 0, 0, "R5", 1);
    step(0, 1, 0, 10, 0, 0, "R5", 1);
    step(1, 0, 0, 10, 0, 0, "R5", 1);
    step(0, 0, 0, 10, 0, 0, "R6", 1);
    step(0, 1, 0, 10, 0, 0, "R5", 1);
    step(0, 1, 0, 10, 0, 0, "R5", 1);

    // R6 / R1: reset with register enable low, release, register enable
    step(1, 1, 0, 11, 0, 0, "R6", 1);
    step(0, 1, 0, 11, 0, 0, "R6", 1);
    step(0, 0, 0, 11, 0, 1, "R1", 1);
    step(1, 0, 0, 11, 0, 1, "R1", 1);
    step(0, 0, 0, 11, 0, 0, "R6", 1);
    step(0, 1, 0, 11, 0, 0, "R6", 1);
    step(0, 1, 0, 11, 0, 0, "R6", 1);

    // R7: asynchronous clear visible in the same cycle it is driven
    step(1, 1, 0, 12, 0, 0, "R7", 1);
    step(0, 1, 0, 12, 0, 0, "R7", 1);
    step(0, 0, 0, 12, 0, 1, "R7", 1);
    step(0, 0, 0, 12, 0, 0, "R7", 1);
    step(1, 0, 0, 12, 0, 0, "R7", 1);
    step(0, 1, 0, 12, 0, 0, "R7", 1);

    // R1: mixed stimulus with sparse resets
    lfsr = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      step(lfsr[0], lfsr[1], lfsr[2] & lfsr[3], lfsr[7:4], lfsr[15:8],
           lfsr[6:4] == 3'b101, "R1", 1);
    end
    step(0, 0, 0, 0, 0, 0, "R1", 0);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule